// File: doc/BRIEF.md
# Threshold-Driven Audio FIFO

This block is a word buffer, 1024 entries of 32 bits by default, that sits between a DMA interface and an audio serializer. One instance is built per direction: a transmit instance is filled by DMA and drained by the serializer, and a receive instance is filled by the serializer and drained by DMA. Both sides use valid/ready handshakes. The block raises a DMA request according to its fill level and a programmable burst threshold. It also reports the exact fill level, so software can estimate latency by dividing the level by the channel count.

The threshold input holds the burst size in words minus one and is clamped to the depth minus one. In per-element mode the threshold is forced to zero, so the request follows single words. On receive, the request is high while more words are stored than the threshold value. On transmit, the request rises once the level drops to the threshold or below, then stays high until the buffer is completely full. This hysteresis lets DMA top the buffer up in one run. A synchronous flush empties the buffer and drops the request. Writes to a full buffer and reads from an empty one are absorbed, and each sets a sticky flag.

Top module: `afifo_thresh`

## Requirements
- R1: Words leave the read port in the order they were accepted at the write port, and the fill level never exceeds the depth.
- R2: The effective threshold is the threshold input clamped to depth minus one when `burst_mode` is 1 (threshold mode), and is 0 when `burst_mode` is 0 (per-element mode).
- R3: With `IS_TX`=0 (receive), `dma_req` is high in the cycle after any cycle whose fill level exceeds the effective threshold, and low in the cycle after any cycle whose level is at or below it.
- R4: With `IS_TX`=1 (transmit), `dma_req` sets in the cycle after the level is at or below the effective threshold. It then stays high until a cycle whose level equals the depth, and is low in the cycle after that.
- R5: `fill_level` counts stored words exactly. A write and a read accepted in the same cycle leave it unchanged.
- R6: When the buffer is full, `wr_ready` is low and a write is dropped, with the level unchanged. The write sets `overflow`, which stays high until reset.
- R7: When the buffer is empty, `rd_valid` is low and `rd_data` is zero. A read attempt leaves the level at zero and sets `underflow`, which stays high until reset.
- R8: A cycle with `flush` high empties the buffer, ignores a simultaneous write, and leaves `dma_req` low in the following cycle. It does not clear the sticky flags.
- R9: While `rst` is high, the level is zero, `dma_req` is low and both sticky flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous empty command |
| burst_mode | input | 1 | 0 = per-element request, 1 = threshold request |
| thr_cfg | input | AW+1 | Burst size in words minus one |
| wr_valid | input | 1 | Write data valid |
| wr_ready | output | 1 | Buffer can accept a word |
| wr_data | input | WIDTH | Write data |
| rd_valid | output | 1 | A word is available |
| rd_ready | input | 1 | Consumer takes the word |
| rd_data | output | WIDTH | Oldest stored word, zero when empty |
| fill_level | output | AW+1 | Number of stored words |
| dma_req | output | 1 | DMA service request |
| overflow | output | 1 | Sticky: write while full |
| underflow | output | 1 | Sticky: read while empty |

## Verification
The assertions assume that `rst` is held high from time zero until the first clock edges. They also assume that `flush`, `thr_cfg` and `burst_mode` are ordinary synchronous inputs, stable across each edge. The bench meets both assumptions by asserting reset at start-up and by changing every input one time step after a rising edge. The over-full and under-empty checks depend on the producer and consumer deliberately ignoring `wr_ready` and `rd_valid`. The directed tasks do this on purpose, driving writes into a full buffer and reads from an empty one.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

    typedef enum logic {
        REQ_PER_WORD = 1'b0,
        REQ_BURST    = 1'b1
    } req_mode_e;

    typedef struct packed {
        logic push;
        logic pop;
        logic ovf_evt;
        logic unf_evt;
    } fifo_op_t;

    function automatic logic [31:0] clamp_u32(input logic [31:0] val, input logic [31:0] lim);
        return (val > lim) ? lim : val;
    endfunction

endpackage

// File: rtl/afifo_store.sv
module afifo_store
    import afifo_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             wr_valid,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_ready,
    output logic             wr_ready,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data,
    output logic [LW-1:0]    level,
    output logic             ovf,
    output logic             unf
);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [AW-1:0]    wptr_q, rptr_q;
    logic [LW-1:0]    cnt_q;
    logic             ovf_q, unf_q;
    logic             full, empty;
    fifo_op_t         op;

    assign full  = (cnt_q == FULL_LVL);
    assign empty = (cnt_q == '0);

    always_comb begin
        op.push    = wr_valid && !full && !flush;
        op.pop     = rd_ready && !empty && !flush;
        op.ovf_evt = wr_valid && full && !flush;
        op.unf_evt = rd_ready && empty && !flush;
    end

    always_ff @(posedge clk) begin
        if (op.push) mem_q[wptr_q] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (op.push) wptr_q <= wptr_q + 1'b1;
            if (op.pop)  rptr_q <= rptr_q + 1'b1;
            case ({op.push, op.pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            if (op.ovf_evt) ovf_q <= 1'b1;
            if (op.unf_evt) unf_q <= 1'b1;
        end
    end

    assign wr_ready = !full;
    assign rd_valid = !empty;
    assign rd_data  = empty ? '0 : mem_q[rptr_q];
    assign level    = cnt_q;
    assign ovf      = ovf_q;
    assign unf      = unf_q;

    a_r1_level_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL_LVL);
    a_r5_push_pop_stable: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && rd_ready && !full && !empty && !flush) |=> $stable(cnt_q));
    a_r6_full_holds: assert property (@(posedge clk) disable iff (rst)
        (full && !flush && !rd_ready) |=> (cnt_q == FULL_LVL));
    a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);
    a_r7_unf_sets: assert property (@(posedge clk) disable iff (rst)
        (rd_ready && empty && !flush) |=> unf_q);
    a_r7_empty_zero: assert property (@(posedge clk) disable iff (rst)
        (!rd_valid) |-> (rd_data == '0));
    a_r8_flush_empty: assert property (@(posedge clk) disable iff (rst)
        flush |=> (cnt_q == '0));
endmodule

// File: rtl/afifo_req.sv
module afifo_req
    import afifo_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter bit IS_TX = 1'b1,
    localparam int LW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  req_mode_e     mode,
    input  logic [LW-1:0] thr_cfg,
    input  logic [LW-1:0] level,
    output logic          req
);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
    localparam logic [LW-1:0] THR_MAX  = LW'(DEPTH - 1);

    logic [LW-1:0] thr_eff;
    logic          req_q;

    always_comb begin
        if (mode == REQ_PER_WORD) thr_eff = '0;
        else thr_eff = LW'(clamp_u32(32'(thr_cfg), 32'(THR_MAX)));
    end

    generate
        if (IS_TX) begin : g_tx
            always_ff @(posedge clk) begin
                if (rst || flush)             req_q <= 1'b0;
                else if (level == FULL_LVL)   req_q <= 1'b0;
                else if (level <= thr_eff)    req_q <= 1'b1;
            end
            a_r4_drop_at_full: assert property (@(posedge clk) disable iff (rst)
                (level == FULL_LVL) |=> !req_q);
            a_r4_hold_until_full: assert property (@(posedge clk) disable iff (rst)
                (req_q && level != FULL_LVL && !flush) |=> req_q);
            a_r4_rise_at_thr: assert property (@(posedge clk) disable iff (rst)
                (level <= thr_eff && level != FULL_LVL && !flush) |=> req_q);
        end else begin : g_rx
            always_ff @(posedge clk) begin
                if (rst || flush) req_q <= 1'b0;
                else              req_q <= (level > thr_eff);
            end
            a_r3_rise: assert property (@(posedge clk) disable iff (rst)
                (level > thr_eff && !flush) |=> req_q);
            a_r3_fall: assert property (@(posedge clk) disable iff (rst)
                (level <= thr_eff) |=> !req_q);
        end
    endgenerate

    a_r2_thr_bound: assert property (@(posedge clk) disable iff (rst)
        thr_eff <= THR_MAX);
    a_r8_flush_drops_req: assert property (@(posedge clk) disable iff (rst)
        flush |=> !req_q);

    assign req = req_q;
endmodule

// File: rtl/afifo_thresh.sv
module afifo_thresh
    import afifo_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int DEPTH = 1024,
    parameter bit IS_TX = 1'b1,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = AW + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             burst_mode,
    input  logic [LW-1:0]    thr_cfg,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [WIDTH-1:0] wr_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [WIDTH-1:0] rd_data,
    output logic [LW-1:0]    fill_level,
    output logic             dma_req,
    output logic             overflow,
    output logic             underflow
);
    logic [LW-1:0] level;
    req_mode_e     mode;

    assign mode = req_mode_e'(burst_mode);

    afifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .rd_ready (rd_ready),
        .wr_ready (wr_ready),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .level    (level),
        .ovf      (overflow),
        .unf      (underflow)
    );

    afifo_req #(.DEPTH(DEPTH), .IS_TX(IS_TX)) u_req (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .mode    (mode),
        .thr_cfg (thr_cfg),
        .level   (level),
        .req     (dma_req)
    );

    assign fill_level = level;

    a_r9_reset_quiet: assert property (@(posedge clk)
        rst |=> (fill_level == '0 && !dma_req && !overflow && !underflow));
endmodule

// File: tb/afifo_thresh_bench.sv
module afifo_thresh_bench;
    localparam int W  = 32;
    localparam int D  = 1024;
    localparam int LW = $clog2(D) + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic          t_flush = 0, t_mode = 1, t_wv = 0, t_rr = 0;
    logic [LW-1:0] t_thr = 11'd4;
    logic [W-1:0]  t_wd = '0;
    logic          t_wrdy, t_rv, t_req, t_ovf, t_unf;
    logic [W-1:0]  t_rd;
    logic [LW-1:0] t_lvl;

    logic          r_flush = 0, r_mode = 1, r_wv = 0, r_rr = 0;
    logic [LW-1:0] r_thr = 11'd3;
    logic [W-1:0]  r_wd = '0;
    logic          r_wrdy, r_rv, r_req, r_ovf, r_unf;
    logic [W-1:0]  r_rd;
    logic [LW-1:0] r_lvl;

    afifo_thresh #(.WIDTH(W), .DEPTH(D), .IS_TX(1'b1)) u_afifo_thresh (
        .clk(clk), .rst(rst), .flush(t_flush), .burst_mode(t_mode), .thr_cfg(t_thr),
        .wr_valid(t_wv), .wr_ready(t_wrdy), .wr_data(t_wd),
        .rd_valid(t_rv), .rd_ready(t_rr), .rd_data(t_rd),
        .fill_level(t_lvl), .dma_req(t_req), .overflow(t_ovf), .underflow(t_unf));

    afifo_thresh #(.WIDTH(W), .DEPTH(D), .IS_TX(1'b0)) u_afifo_thresh_rx (
        .clk(clk), .rst(rst), .flush(r_flush), .burst_mode(r_mode), .thr_cfg(r_thr),
        .wr_valid(r_wv), .wr_ready(r_wrdy), .wr_data(r_wd),
        .rd_valid(r_rv), .rd_ready(r_rr), .rd_data(r_rd),
        .fill_level(r_lvl), .dma_req(r_req), .overflow(r_ovf), .underflow(r_unf));

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic push_tx(input int n, input logic [31:0] base);
        for (int i = 0; i < n; i++) begin
            t_wv = 1; t_wd = base + 32'(i);
            step();
        end
        t_wv = 0;
    endtask

    task automatic push_rx(input int n, input logic [31:0] base);
        for (int i = 0; i < n; i++) begin
            r_wv = 1; r_wd = base + 32'(i);
            step();
        end
        r_wv = 0;
    endtask

    task automatic pop_tx(input int n, input logic [31:0] base);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            t_rr = 1;
            #1;
            if (t_rd !== base + 32'(i)) bad++;
            step();
        end
        t_rr = 0;
        chk("R1 tx read order mismatches", 32'(bad), 0);
    endtask

    task automatic pop_rx_one(input logic [31:0] exp, input string tag);
        r_rr = 1;
        #1;
        chk(tag, r_rd, exp);
        step();
        r_rr = 0;
    endtask

    task automatic t_reset();
        rst = 1;
        repeat (3) step();
        chk("R9 tx level in reset", 32'(t_lvl), 0);
        chk("R9 tx req in reset", 32'(t_req), 0);
        chk("R9 rx req in reset", 32'(r_req), 0);
        chk("R9 flags in reset", {28'd0, t_ovf, t_unf, r_ovf, r_unf}, 0);
        chk("R9 wr_ready in reset", 32'(t_wrdy), 1);
        chk("R7 rd_valid empty", 32'(r_rv), 0);
        rst = 0;
        step();
        chk("R4 tx req after reset (level 0 <= thr 4)", 32'(t_req), 1);
        chk("R3 rx req after reset", 32'(r_req), 0);
    endtask

    task automatic t_rx_threshold();
        push_rx(3, 32'hA000_0000);
        step();
        chk("R5 rx level 3", 32'(r_lvl), 3);
        chk("R3 rx req low at level 3 thr 3", 32'(r_req), 0);
        push_rx(1, 32'hA000_0003);
        step();
        chk("R3 rx req high at level 4", 32'(r_req), 1);
        pop_rx_one(32'hA000_0000, "R1 rx first word");
        step();
        chk("R3 rx req low after drop to 3", 32'(r_req), 0);
        r_wv = 1; r_wd = 32'hA000_0004; r_rr = 1;
        #1;
        chk("R1 rx word during push+pop", r_rd, 32'hA000_0001);
        step();
        r_wv = 0; r_rr = 0;
        chk("R5 level unchanged on push+pop", 32'(r_lvl), 3);
        pop_rx_one(32'hA000_0002, "R1 rx word 2");
        pop_rx_one(32'hA000_0003, "R1 rx word 3");
        pop_rx_one(32'hA000_0004, "R1 rx word 4");
        chk("R5 rx level empty", 32'(r_lvl), 0);
    endtask

    task automatic t_underflow();
        r_rr = 1;
        #1;
        chk("R7 rd_data zero when empty", r_rd, 0);
        step();
        r_rr = 0;
        chk("R7 underflow set", 32'(r_unf), 1);
        chk("R7 level stays 0", 32'(r_lvl), 0);
        step();
        chk("R7 underflow sticky", 32'(r_unf), 1);
    endtask

    task automatic t_per_element_and_flush();
        r_mode = 0; r_thr = 11'd7;
        push_rx(1, 32'hB000_0000);
        step();
        chk("R2 per-element req with one word", 32'(r_req), 1);
        r_flush = 1; r_wv = 1; r_wd = 32'hDEAD_BEEF;
        step();
        r_flush = 0; r_wv = 0;
        chk("R8 flush empties", 32'(r_lvl), 0);
        chk("R8 flush drops req", 32'(r_req), 0);
        chk("R8 flags kept over flush", 32'(r_unf), 1);
    endtask

    task automatic t_clamp_overflow();
        r_mode = 1; r_thr = 11'h7FF;
        push_rx(D - 1, 32'hC000_0000);
        step();
        chk("R2 clamped thr: req low at depth-1", 32'(r_req), 0);
        push_rx(1, 32'hC000_0000 + 32'(D - 1));
        step();
        chk("R2 clamped thr: req high at depth", 32'(r_req), 1);
        chk("R6 wr_ready low when full", 32'(r_wrdy), 0);
        push_rx(1, 32'hEEEE_EEEE);
        chk("R6 level unchanged on overflow", 32'(r_lvl), D);
        chk("R6 overflow set", 32'(r_ovf), 1);
        pop_rx_one(32'hC000_0000, "R6 dropped write did not overwrite head");
        r_flush = 1;
        step();
        r_flush = 0;
        chk("R6 overflow sticky over flush", 32'(r_ovf), 1);
    endtask

    task automatic t_tx_hysteresis();
        push_tx(10, 32'h1000_0000);
        step();
        chk("R4 tx req holds above thr", 32'(t_req), 1);
        push_tx(D - 10, 32'h1000_000A);
        step();
        chk("R5 tx level full", 32'(t_lvl), D);
        chk("R4 tx req drops at full", 32'(t_req), 0);
        pop_tx(D - 5, 32'h1000_0000);
        step();
        chk("R4 tx req stays low at level 5", 32'(t_req), 0);
        pop_tx(1, 32'h1000_0000 + 32'(D - 5));
        step();
        chk("R4 tx req rises at level 4", 32'(t_req), 1);
        t_flush = 1;
        step();
        t_flush = 0;
        chk("R8 tx flush level", 32'(t_lvl), 0);
        chk("R8 tx flush req", 32'(t_req), 0);
        step();
        chk("R4 tx req returns after flush", 32'(t_req), 1);
        chk("R7 tx underflow never set", 32'(t_unf), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_rx_threshold();
        t_underflow();
        t_per_element_and_flush();
        t_clamp_overflow();
        t_tx_hysteresis();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule